// File: doc/BRIEF.md
# UART receiver idle timeout

This block watches the gap after each received serial character and raises a status flag when the line has been quiet for a programmed number of bit periods. Software uses the flag, or the interrupt derived from it, to find the end of a variable-length frame without knowing the frame's length in advance. The block counts ticks from the baud generator, one per bit period. It restarts its count on each character-received pulse from the serial receiver.

Two commands restart the timer. The arm command clears the flag, loads the count and then holds the count frozen until a character arrives. A timeout that follows can therefore only mean that a frame has ended. The reload command clears the flag, loads the count and starts counting at once. If it is issued after each timeout, the block gives periodic idle interrupts, for example to notice that no key has been pressed. A programmed value of zero turns the feature off.

Top module: `rx_idle_timer`

## Requirements
- R1: While the timeout value input is zero the feature is off. The flag is cleared on the next clock edge, never sets, and the interrupt stays low, whatever ticks, characters or commands arrive.
- R2: After reset the flag and interrupt are low and the timer is frozen waiting for a character. Ticks with no character produce no timeout.
- R3: While running, the 8-bit counter decrements by one per tick. The flag goes high on the clock edge that takes in the N-th tick after a load with value N.
- R4: A character pulse reloads the counter with the programmed value and starts it running, also in the middle of a count. The timeout is therefore measured from the last character.
- R5: The flag is sticky. More ticks and character pulses leave it set, and only a command, disabling (R1) or reset clears it. After expiry the counter holds at zero and does not wrap.
- R6: The arm command clears the flag, loads the value and freezes the count. Any number of ticks before the next character gives no timeout, and after that character N ticks give a timeout.
- R7: The reload command clears the flag, loads the value and counts at once. Issuing it again after each timeout gives a timeout every N ticks.
- R8: When a tick and a character pulse arrive in the same cycle, the reload wins and the tick is not counted.
- R9: When a command and a character pulse arrive in the same cycle, the command's mode takes effect: arm leaves the count frozen, and reload leaves it running. When both commands arrive together, reload wins.
- R10: The interrupt output equals the flag ANDed with the interrupt-enable input, with no added delay.
- R11: A value of 255 gives the longest timeout. There is no flag after 254 ticks and the flag is set after the 255th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| timeout_val_i | input | 8 | Programmed timeout in bit periods; zero disables |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| char_rx_i | input | 1 | One-cycle pulse per received character |
| cmd_arm_i | input | 1 | Arm command: clear flag, load, wait for a character |
| cmd_reload_i | input | 1 | Reload command: clear flag, load, count at once |
| irq_en_i | input | 1 | Interrupt enable |
| timeout_flag_o | output | 1 | Sticky timeout status flag |
| irq_o | output | 1 | Timeout flag gated by irq_en_i |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions: a tick against a character, a command against a character, and the two commands together. In each case one of the events silently loses. The loser shows only as a timeout that comes one tick later than it otherwise would, or that never comes. The stimulus table places these collisions right after a frozen or expired state and then counts the exact number of ticks until the flag rises. A directed run of 255 ticks checks the top of the counter range without wrap.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  localparam int unsigned CNT_W_DEF  = 8;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    MODE_HOLD = 1'b0,
    MODE_RUN  = 1'b1
  } run_mode_e;
endpackage

// File: rtl/rxto_rst_sync.sv
module rxto_rst_sync #(
  parameter int unsigned STAGES = rxto_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rxto_counter.sv
module rxto_counter #(
  parameter int unsigned CNT_W = rxto_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;

  assign cnt_en = load_i | dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (dec_i) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/rxto_ctrl.sv
module rxto_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic bit_tick_i,
  input  logic char_rx_i,
  input  logic cmd_arm_i,
  input  logic cmd_reload_i,
  input  logic last_i,
  output logic load_o,
  output logic dec_o,
  output logic set_o,
  output logic clr_o,
  output logic run_o
);
  import rxto_pkg::*;

  run_mode_e mode_d, mode_q;
  logic      any_load;

  assign any_load = enable_i & (cmd_reload_i | cmd_arm_i | char_rx_i);
  assign load_o   = any_load;
  assign dec_o    = enable_i & (mode_q == MODE_RUN) & bit_tick_i & ~any_load;
  assign set_o    = dec_o & last_i;
  assign clr_o    = ~enable_i | cmd_reload_i | cmd_arm_i;

  always_comb begin
    mode_d = mode_q;
    if (!enable_i)         mode_d = MODE_HOLD;
    else if (cmd_reload_i) mode_d = MODE_RUN;
    else if (cmd_arm_i)    mode_d = MODE_HOLD;
    else if (char_rx_i)    mode_d = MODE_RUN;
    else if (set_o)        mode_d = MODE_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_HOLD;
    else         mode_q <= mode_d;
  end

  assign run_o = (mode_q == MODE_RUN);
endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_d, flag_q, flag_en;

  assign flag_en = set_i | clr_i;

  always_comb begin
    flag_d = flag_q;
    if (clr_i)      flag_d = 1'b0;
    else if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int unsigned CNT_W = rxto_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] timeout_val_i,
  input  logic             bit_tick_i,
  input  logic             char_rx_i,
  input  logic             cmd_arm_i,
  input  logic             cmd_reload_i,
  input  logic             irq_en_i,
  output logic             timeout_flag_o,
  output logic             irq_o
);
  logic             rst_sync_n;
  logic             enable;
  logic             load, dec, set, clr, last, run_w;
  logic [CNT_W-1:0] cnt_w;

  assign enable = (timeout_val_i != '0);

  rxto_rst_sync i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  rxto_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .enable_i     (enable),
    .bit_tick_i   (bit_tick_i),
    .char_rx_i    (char_rx_i),
    .cmd_arm_i    (cmd_arm_i),
    .cmd_reload_i (cmd_reload_i),
    .last_i       (last),
    .load_o       (load),
    .dec_o        (dec),
    .set_o        (set),
    .clr_o        (clr),
    .run_o        (run_w)
  );

  rxto_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .load_i     (load),
    .load_val_i (timeout_val_i),
    .dec_i      (dec),
    .cnt_o      (cnt_w),
    .last_o     (last)
  );

  rxto_flag i_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .set_i    (set),
    .clr_i    (clr),
    .irq_en_i (irq_en_i),
    .flag_o   (timeout_flag_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/rxto_chk.sv
module rxto_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic [CNT_W-1:0] tv,
  input logic             tick,
  input logic             chr,
  input logic             arm,
  input logic             rld,
  input logic             ien,
  input logic             flag,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             run
);
  logic en;
  assign en = (tv != '0);

  assert_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en |=> !flag);

  assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en && run && tick && !chr && !arm && !rld) |=> (cnt == $past(cnt) - 1'b1));

  assert_flag_needs_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(flag) |-> $past(tick));

  assert_char_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en && chr && !arm && !rld) |=> (run && cnt == $past(tv)));

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en && flag && !arm && !rld) |=> flag);

  assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    run |-> (cnt != '0));

  assert_arm_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en && arm && !rld) |=> (!run && !flag && cnt == $past(tv)));

  assert_reload_run_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en && rld) |=> (run && !flag && cnt == $past(tv)));

  assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq == (flag && ien));
endmodule

bind rx_idle_timer rxto_chk #(.CNT_W(CNT_W)) i_rxto_chk (
  .clk_i (clk_i),
  .rst_n (rst_sync_n),
  .tv    (timeout_val_i),
  .tick  (bit_tick_i),
  .chr   (char_rx_i),
  .arm   (cmd_arm_i),
  .rld   (cmd_reload_i),
  .ien   (irq_en_i),
  .flag  (timeout_flag_o),
  .irq   (irq_o),
  .cnt   (cnt_w),
  .run   (run_w)
);

// File: tb/test_rx_idle_timer.sv
`timescale 1ns/1ps
module test_rx_idle_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] tv;
  logic       tick, chr, arm, rld, ien;
  logic       flag, irq;
  int         total = 0;
  int         bad   = 0;

  always #10 clk = ~clk;

  rx_idle_timer i_rx_idle_timer (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .timeout_val_i  (tv),
    .bit_tick_i     (tick),
    .char_rx_i      (chr),
    .cmd_arm_i      (arm),
    .cmd_reload_i   (rld),
    .irq_en_i       (ien),
    .timeout_flag_o (flag),
    .irq_o          (irq)
  );

  // row: req[18:15] tv[14:7] chr tick arm rld ien [6:2] exp_flag exp_irq [1:0]
  localparam int NV = 41;
  localparam logic [18:0] VEC [NV] = '{
    {4'd2,  8'd3, 5'b01001, 2'b00},  // R2 frozen after reset
    {4'd2,  8'd3, 5'b01001, 2'b00},
    {4'd4,  8'd3, 5'b10001, 2'b00},  // R4 char starts count
    {4'd3,  8'd3, 5'b01001, 2'b00},
    {4'd3,  8'd3, 5'b01001, 2'b00},
    {4'd3,  8'd3, 5'b01001, 2'b11},  // R3 third tick sets flag
    {4'd5,  8'd3, 5'b01001, 2'b11},  // R5 extra tick, still set
    {4'd5,  8'd3, 5'b10001, 2'b11},  // R5 char does not clear
    {4'd10, 8'd3, 5'b00000, 2'b10},  // R10 irq masked
    {4'd6,  8'd3, 5'b00101, 2'b00},  // R6 arm clears, freezes
    {4'd6,  8'd3, 5'b01001, 2'b00},
    {4'd6,  8'd3, 5'b01001, 2'b00},
    {4'd6,  8'd3, 5'b01001, 2'b00},
    {4'd8,  8'd3, 5'b11001, 2'b00},  // R8 char+tick: reload wins
    {4'd8,  8'd3, 5'b01001, 2'b00},
    {4'd8,  8'd3, 5'b01001, 2'b00},
    {4'd4,  8'd3, 5'b10001, 2'b00},  // R4 mid-count reload
    {4'd4,  8'd3, 5'b01001, 2'b00},
    {4'd4,  8'd3, 5'b01001, 2'b00},
    {4'd4,  8'd3, 5'b01001, 2'b11},
    {4'd7,  8'd3, 5'b00011, 2'b00},  // R7 reload runs at once
    {4'd7,  8'd3, 5'b01001, 2'b00},
    {4'd7,  8'd3, 5'b01001, 2'b00},
    {4'd7,  8'd3, 5'b01001, 2'b11},
    {4'd7,  8'd3, 5'b00011, 2'b00},  // R7 periodic second round
    {4'd7,  8'd3, 5'b01001, 2'b00},
    {4'd7,  8'd3, 5'b01001, 2'b00},
    {4'd7,  8'd3, 5'b01001, 2'b11},
    {4'd9,  8'd3, 5'b10101, 2'b00},  // R9 arm+char stays frozen
    {4'd9,  8'd3, 5'b01001, 2'b00},
    {4'd9,  8'd3, 5'b01001, 2'b00},
    {4'd9,  8'd3, 5'b01001, 2'b00},
    {4'd9,  8'd3, 5'b10011, 2'b00},  // R9 reload+char runs
    {4'd9,  8'd3, 5'b01001, 2'b00},
    {4'd9,  8'd3, 5'b01001, 2'b00},
    {4'd9,  8'd3, 5'b01001, 2'b11},
    {4'd1,  8'd0, 5'b00011, 2'b00},  // R1 zero value disables
    {4'd1,  8'd0, 5'b10001, 2'b00},
    {4'd1,  8'd0, 5'b01001, 2'b00},
    {4'd1,  8'd0, 5'b01001, 2'b00},
    {4'd1,  8'd0, 5'b01001, 2'b00}
  };

  task automatic check(input string req, input logic ef, input logic ei);
    total++;
    if (flag !== ef || irq !== ei) begin
      bad++;
      $display("FAIL %s flag=%b irq=%b expected flag=%b irq=%b", req, flag, irq, ef, ei);
    end
  endtask

  // drive one cycle at the falling edge, return at the next falling edge
  task automatic cycle(input logic c, input logic t, input logic a, input logic r);
    chr = c; tick = t; arm = a; rld = r;
    @(negedge clk);
    chr = 1'b0; tick = 1'b0; arm = 1'b0; rld = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tv = 8'd3; tick = 0; chr = 0; arm = 0; rld = 0; ien = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    check("R2", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v   = VEC[i];
      tv  = v[14:7];
      ien = v[2];
      cycle(v[6], v[5], v[4], v[3]);
      check($sformatf("R%0d row %0d", v[18:15], i), v[1], v[0]);
    end

    // R1: disabling while flag is set clears it
    tv = 8'd2; ien = 1'b1;
    cycle(0, 0, 0, 1);
    cycle(0, 1, 0, 0);
    cycle(0, 1, 0, 0);
    check("R1 precondition", 1'b1, 1'b1);
    tv = 8'd0;
    cycle(0, 0, 0, 0);
    check("R1 disable clears", 1'b0, 1'b0);

    // R9: both commands together, reload wins
    tv = 8'd2;
    cycle(0, 0, 1, 1);
    cycle(0, 1, 0, 0);
    check("R9 both cmds", 1'b0, 1'b0);
    cycle(0, 1, 0, 0);
    check("R9 both cmds", 1'b1, 1'b1);

    // R2: reset clears a set flag and freezes the timer
    do_reset();
    check("R2 after reset", 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) cycle(0, 1, 0, 0);
    check("R2 frozen after reset", 1'b0, 1'b0);

    // R11: maximum value
    tv = 8'd255;
    cycle(0, 0, 0, 1);
    for (int k = 0; k < 254; k++) cycle(0, 1, 0, 0);
    check("R11 at 254 ticks", 1'b0, 1'b0);
    cycle(0, 1, 0, 0);
    check("R11 at 255 ticks", 1'b1, 1'b1);
    ien = 1'b0;
    #1;
    check("R10 mask comb", 1'b1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule